// File: doc/BRIEF.md
# UART Modem Status Register

This block holds the 8-bit modem status register of a 16550-style serial port. Four active-low modem handshake inputs come in: carrier detect, ring indicator, data set ready and clear to send. Each passes through a synchronizer. The register reports the present asserted level of each line in its upper four bits. The lower four bits are sticky change flags, which software clears by reading the register.

A loopback control replaces the external pins with four modem-control outputs of the port. This lets the status logic be tested without a modem attached. A modem-status interrupt request goes high whenever a change flag is set and the interrupt enable input is high. Bus decoding, interrupt prioritisation and the rest of the serial datapath sit outside this block. The host presents a one-cycle read strobe and samples `rd_data` in that cycle.

Top module: `modem_status_reg`

## Requirements
- R1: With loopback off, `rd_data[7]`, `[6]`, `[5]` and `[4]` are the logical complements of `pin_dcd_n`, `pin_ri_n`, `pin_dsr_n` and `pin_cts_n` respectively, so an asserted (low) pin reads as 1.
- R2: While `rst_n` is low, and right after it is released with all pins deasserted (high), `rd_data` is 8'h00 and `irq` is 0.
- R3: With `lpbk_en` = 1, `rd_data[7:4]` equals {`ctl_out2`, `ctl_out1`, `ctl_dtr`, `ctl_rts`}, and changes on the four external pins have no effect on `rd_data`.
- R4: Bits 3, 1 and 0 are set by any change (either direction) of the carrier detect, data set ready and clear to send levels respectively, and stay set until a read.
- R5: A cycle with `rd_stb` = 1 clears every lower-nibble flag that was 1 in the `rd_data` returned in that cycle, unless a new change arrives in the same cycle.
- R6: If a modem pin is held asserted through reset, its change flag is set after reset is released. This applies to bits 3, 1 and 0. With all four pins held asserted, the register settles to 8'hFB.
- R7: Bit 2 is set only when the ring indicator level goes from asserted to deasserted (pin low to high, or `ctl_out1` 1 to 0 in loopback). An assertion does not set it.
- R8: A change detected in the same cycle as a read leaves its flag set after that read.
- R9: `irq` is 1 exactly when `irq_en` is 1 and at least one of `rd_data[3:0]` is 1.
- R10: An external pin edge appears in `rd_data[7:4]` on the third rising clock edge after it, and the matching flag appears one edge later. In loopback, a control change appears on the next edge, and its flag appears one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_dcd_n | input | 1 | Carrier detect pin, active low |
| pin_ri_n | input | 1 | Ring indicator pin, active low |
| pin_dsr_n | input | 1 | Data set ready pin, active low |
| pin_cts_n | input | 1 | Clear to send pin, active low |
| lpbk_en | input | 1 | Loopback mode select |
| ctl_dtr | input | 1 | Modem-control DTR output, feeds bit 5 in loopback |
| ctl_rts | input | 1 | Modem-control RTS output, feeds bit 4 in loopback |
| ctl_out1 | input | 1 | Modem-control OUT1 output, feeds bit 6 in loopback |
| ctl_out2 | input | 1 | Modem-control OUT2 output, feeds bit 7 in loopback |
| rd_stb | input | 1 | Register read strobe, one cycle per read |
| rd_data | output | 8 | Register contents |
| irq_en | input | 1 | Modem-status interrupt enable |
| irq | output | 1 | Modem-status interrupt request |

## Verification
On every cycle, the assertions check the following:
- flags hold until a read;
- a read with no coincident change clears its flags;
- every detected change lands in its flag;
- the loopback levels follow the control outputs;
- bit 2 rises only after a falling ring level;
- `irq` agrees with the enable and the flags.

Only the bench scenarios can show the remaining behaviour. These cover the exact pin-to-register latency through the synchronizer, the complement mapping of each pin, and the 8'hFB state after a reset with pins held asserted. They also cover pins being ignored in loopback and a change arriving in the same cycle as a read. A sweep over all sixteen pin patterns and all sixteen loopback control patterns compares every step against flags computed in the bench.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NLINES  = 4;
  localparam int IDX_DCD = 3;
  localparam int IDX_RI  = 2;
  localparam int IDX_DSR = 1;
  localparam int IDX_CTS = 0;

  // Active-high line level: control outputs in loopback, inverted pins otherwise.
  function automatic logic [NLINES-1:0] select_level(input logic lp,
                                                     input logic [NLINES-1:0] pin_n,
                                                     input logic [NLINES-1:0] ctl);
    return lp ? ctl : ~pin_n;
  endfunction

  // Change event: any toggle, or only asserted-to-deasserted when trail_only.
  function automatic logic delta_event(input logic prev, input logic cur,
                                       input logic trail_only);
    return trail_only ? (prev & ~cur) : (prev ^ cur);
  endfunction

  // Sticky flag update; a new event wins over a clearing read.
  function automatic logic next_flag(input logic flag, input logic evt,
                                     input logic clr);
    return evt | (flag & ~clr);
  endfunction
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_n,
  output logic [W-1:0] q_n
);
  logic [W-1:0] stg [STAGES];

  // Stages reset to the deasserted (high) level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d_n;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_n = stg[STAGES-1];
endmodule

// File: rtl/msr_edge.sv
module msr_edge #(
  parameter bit TRAIL_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rd_clr,
  output logic cur,
  output logic flag,
  output logic evt
);
  logic cur_q, prev_q, flag_q;

  // Present and previous levels reset to deasserted, so a line held
  // asserted at reset release yields an event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cur_q  <= lvl;
      prev_q <= cur_q;
      flag_q <= msr_pkg::next_flag(flag_q, evt, rd_clr);
    end
  end

  assign evt  = msr_pkg::delta_event(prev_q, cur_q, TRAIL_ONLY);
  assign cur  = cur_q;
  assign flag = flag_q;
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_dcd_n,
  input  logic       pin_ri_n,
  input  logic       pin_dsr_n,
  input  logic       pin_cts_n,
  input  logic       lpbk_en,
  input  logic       ctl_dtr,
  input  logic       ctl_rts,
  input  logic       ctl_out1,
  input  logic       ctl_out2,
  input  logic       rd_stb,
  output logic [7:0] rd_data,
  input  logic       irq_en,
  output logic       irq
);
  import msr_pkg::*;

  localparam int NL = NLINES;

  logic [NL-1:0] pins_n, pins_sync_n, ctl_vec, line_lvl;
  logic [NL-1:0] line_cur, line_flag, line_evt;

  // Line vectors ordered {carrier, ring, data set ready, clear to send}.
  assign pins_n  = {pin_dcd_n, pin_ri_n, pin_dsr_n, pin_cts_n};
  assign ctl_vec = {ctl_out2, ctl_out1, ctl_dtr, ctl_rts};

  msr_sync #(.W(NL), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_n   (pins_n),
    .q_n   (pins_sync_n)
  );

  assign line_lvl = select_level(lpbk_en, pins_sync_n, ctl_vec);

  for (genvar i = 0; i < NL; i++) begin : g_line
    msr_edge #(.TRAIL_ONLY(i == IDX_RI)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (line_lvl[i]),
      .rd_clr (rd_stb),
      .cur    (line_cur[i]),
      .flag   (line_flag[i]),
      .evt    (line_evt[i])
    );
  end

  assign rd_data = {line_cur, line_flag};
  assign irq     = irq_en & (|line_flag);
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       irq_en,
  input logic       lpbk_en,
  input logic [3:0] ctl_vec,
  input logic [3:0] evt
);
  // R4: flags are sticky while no read happens
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));

  // R5: a read without a coincident change clears the flags
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && evt == 4'b0000) |=> rd_data[3:0] == 4'b0000);

  // R8: a detected change always lands in its flag, even during a read
  p_evt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 4'b0000) |=> ((rd_data[3:0] & $past(evt)) == $past(evt)));

  // R3: loopback levels follow the control outputs one edge later
  p_loopback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lpbk_en |=> rd_data[7:4] == $past(ctl_vec));

  // R7: ring flag rises only after the ring level fell
  p_ring_trail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[2]) |-> ($past(rd_data[6], 2) && !$past(rd_data[6])));

  // R9: interrupt request needs the enable, and any flag with enable raises it
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
  p_irq_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && rd_data[3:0] != 4'b0000) |-> irq);
endmodule

bind modem_status_reg msr_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_stb  (rd_stb),
  .rd_data (rd_data),
  .irq     (irq),
  .irq_en  (irq_en),
  .lpbk_en (lpbk_en),
  .ctl_vec ({ctl_out2, ctl_out1, ctl_dtr, ctl_rts}),
  .evt     (line_evt)
);

// File: tb/tb_modem_status_reg.sv
module tb_modem_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pin_n = 4'hF;   // {dcd, ri, dsr, cts}
  logic [3:0] ctl = 4'h0;     // {out2, out1, dtr, rts}
  logic lpbk_en = 1'b0, rd_stb = 1'b0, irq_en = 1'b0;
  logic [7:0] rd_data;
  logic irq;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  modem_status_reg dut (
    .clk(clk), .rst_n(rst_n),
    .pin_dcd_n(pin_n[3]), .pin_ri_n(pin_n[2]), .pin_dsr_n(pin_n[1]), .pin_cts_n(pin_n[0]),
    .lpbk_en(lpbk_en), .ctl_dtr(ctl[1]), .ctl_rts(ctl[0]), .ctl_out1(ctl[2]), .ctl_out2(ctl[3]),
    .rd_stb(rd_stb), .rd_data(rd_data), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk); rd_stb = 1'b1; #1 v = rd_data;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  function automatic logic [3:0] exp_flags(input logic [3:0] prv, input logic [3:0] nxt);
    logic [3:0] c;
    c = prv ^ nxt;
    return {c[3], prv[2] & ~nxt[2], c[1], c[0]};
  endfunction

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [3:0] prv;
    repeat (3) @(negedge clk);
    chk("R2 in reset", rd_data, 8'h00);
    chk("R2 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 after release", rd_data, 8'h00);

    // R1/R4/R7 sweep over pin patterns (active-high levels p)
    prv = 4'h0;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] p;
      p = 4'((i * 7 + 3) & 15);
      @(negedge clk); pin_n = ~p;
      repeat (5) @(negedge clk);
      chk("R1 R4 R7 pin sweep", rd_data, {p, exp_flags(prv, p)});
      do_read(v);
      chk("R5 read clears", rd_data, {p, 4'h0});
      prv = p;
    end
    @(negedge clk); pin_n = 4'hF;
    repeat (5) @(negedge clk);
    do_read(v);
    chk("R5 idle", rd_data, 8'h00);

    // R10 latency on carrier detect
    @(negedge clk); pin_n[3] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 not yet", rd_data, 8'h00);
    @(negedge clk);
    chk("R10 level third edge", rd_data, 8'h80);
    @(negedge clk);
    chk("R10 flag next edge", rd_data, 8'h88);
    @(negedge clk); pin_n = 4'hF;
    repeat (5) @(negedge clk);
    do_read(v);

    // R3 loopback sweep
    @(negedge clk); lpbk_en = 1'b1; ctl = 4'h0;
    repeat (3) @(negedge clk);
    do_read(v);
    chk("R3 loopback entry", rd_data, 8'h00);
    prv = 4'h0;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] c;
      c = 4'((i * 5 + 1) & 15);
      @(negedge clk); ctl = c;
      chk("R10 loopback pre", rd_data, {prv, 4'h0});
      @(negedge clk);
      chk("R10 loopback level", rd_data[7:4], {4'h0, c});
      @(negedge clk);
      chk("R3 R7 loopback sweep", rd_data, {c, exp_flags(prv, c)});
      do_read(v);
      prv = c;
    end
    @(negedge clk); ctl = 4'hF;
    repeat (3) @(negedge clk);
    do_read(v);
    @(negedge clk); pin_n = 4'h0;
    repeat (6) @(negedge clk);
    chk("R3 pins ignored", rd_data, 8'hF0);
    @(negedge clk); pin_n = 4'hF;
    repeat (6) @(negedge clk);
    chk("R3 pins ignored back", rd_data, 8'hF0);

    // R8 change coincident with read (carrier via out2)
    @(negedge clk); ctl[3] = 1'b0;
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk("R8 flag survives read", rd_data, 8'h78);

    // R9 interrupt gating
    #1 chk("R9 irq disabled", {7'd0, irq}, 8'h00);
    irq_en = 1'b1;
    #1 chk("R9 irq enabled", {7'd0, irq}, 8'h01);
    do_read(v);
    #1 chk("R9 irq after clear", {7'd0, irq}, 8'h00);

    // R6 pins asserted through reset
    @(negedge clk); rst_n = 1'b0; lpbk_en = 1'b0; ctl = 4'h0; pin_n = 4'h0;
    repeat (3) @(negedge clk);
    chk("R2 reset with pins asserted", rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 flags after release", rd_data, 8'hFB);
    do_read(v);
    chk("R6 read value", v, 8'hFB);
    chk("R5 R6 cleared", rd_data, 8'hF0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule